// File: doc/BRIEF.md
# Idle-Window Sleep Depth Selector

This block sits beside a real-time task scheduler. When the processor runs out of work, the scheduler pulses a start strobe. With that strobe it presents the number of time units left before the next task is due to start. The block picks the deepest power-saving depth that fits in that window: stay awake, light sleep or heavy sleep. The choice counts both the cost of getting into a depth and the fixed cost of coming back out. The block then steps the processor through the entry sequence. Heavy sleep is always reached by way of light sleep. It times the exit so that the processor is back in normal mode on the exact time unit at which the window closes.

A level input bans heavy sleep while a fast-response event may arrive. An interrupt aborts entry or sleep at any point and starts the fixed-length exit at once. Exit always lands in normal mode. Per-mode time-unit counters report how long the processor spent at each depth. An error counter records start strobes that arrive while the block is busy and are therefore ignored. All durations are counted in pulses of `tick_i`. The countdown of a window begins with the first tick after the strobe.

Top module: `sleep_depth_ctrl`

## Requirements
- R1: After reset, mode_o is 0 (normal), ready_o is 1, enter_o and exit_o are 0, and all counters are 0.
- R2: A start strobe with an idle length of 4 or less leaves the block in normal mode with ready_o high and enter_o low.
- R3: A start strobe with an idle length of 5 or 6 asserts enter_o for 2 ticks. mode_o then reads 1 (light) and never reads 2 (heavy) in that window.
- R4: An idle length of 7 or more with the ban low selects heavy sleep. mode_o reads 0 for the first 2 ticks and 1 for the next 2 ticks, with enter_o high throughout. It then reads 2 (heavy). mode_o never steps from 0 straight to 2.
- R5: While ban_heavy_i is high at the strobe, any idle length of 5 or more selects light sleep.
- R6: exit_o is high for exactly the last 2 ticks of the window. ready_o returns to 1 on the tick that completes the idle length and not one tick earlier.
- R7: Leaving light or heavy sleep always ends in mode 0. mode_o never moves from 2 to 1.
- R8: An interrupt while entering or asleep raises exit_o on the next cycle. ready_o returns after 2 more ticks. An interrupt in normal mode has no effect.
- R9: A start strobe while ready_o is low is ignored and increments err_cnt_o by one.
- R10: normal_time_o, light_time_o and heavy_time_o each count the ticks during which mode_o held 0, 1 or 2 respectively.
- R11: mode_o never reads 3. enter_o and exit_o are never high together. ready_o is high only in mode 0 with both commands low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Idle-window start strobe |
| idle_len_i | input | IDLE_W | Time units until the next task start |
| irq_i | input | 1 | Wake interrupt |
| ban_heavy_i | input | 1 | Forbids heavy sleep when high at the strobe |
| tick_i | input | 1 | One time-unit pulse |
| mode_o | output | 2 | Current depth: 0 normal, 1 light, 2 heavy |
| enter_o | output | 1 | Entry sequence in progress |
| exit_o | output | 1 | Wake sequence in progress |
| ready_o | output | 1 | Awake and accepting a strobe |
| normal_time_o | output | CNT_W | Ticks spent in mode 0 |
| light_time_o | output | CNT_W | Ticks spent in mode 1 |
| heavy_time_o | output | CNT_W | Ticks spent in mode 2 |
| err_cnt_o | output | CNT_W | Strobes ignored while busy |

## Verification
The checker watches the mode ladder on every cycle: no jump from normal to heavy and no step from heavy back to light. It also checks the command exclusivity and the meaning of ready. Short windows must leave the block awake. An interrupt must start the exit on the next cycle, and an ignored strobe must add exactly one to the error count. Only the bench scenarios can show the window arithmetic. That covers the depth chosen for each length and the ban, the tick on which exit starts and ready returns, and the per-mode time totals.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_LIGHT  = 2'd1,
        MODE_HEAVY  = 2'd2
    } sdc_mode_e;

    typedef enum logic [2:0] {
        ST_AWAKE,
        ST_TO_LIGHT,
        ST_TO_HEAVY,
        ST_SLEEP,
        ST_WAKING
    } sdc_state_e;
endpackage

// File: rtl/sdc_depth_pick.sv
module sdc_depth_pick
    import sdc_pkg::*;
#(
    parameter int IDLE_W  = 16,
    parameter int ENTER_L = 2,
    parameter int ENTER_H = 2,
    parameter int WAKE    = 2
) (
    input  logic [IDLE_W-1:0] idle_len_i,
    input  logic              ban_heavy_i,
    output sdc_mode_e         depth_o
);
    // a depth is worth it only if the window exceeds its full round-trip cost
    localparam int LIGHT_MIN = ENTER_L + WAKE + 1;
    localparam int HEAVY_MIN = ENTER_L + ENTER_H + WAKE + 1;

    always_comb begin
        if (idle_len_i >= IDLE_W'(HEAVY_MIN) && !ban_heavy_i) begin
            depth_o = MODE_HEAVY;
        end else if (idle_len_i >= IDLE_W'(LIGHT_MIN)) begin
            depth_o = MODE_LIGHT;
        end else begin
            depth_o = MODE_NORMAL;
        end
    end
endmodule

// File: rtl/sdc_event_cnt.sv
module sdc_event_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc_i) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/sleep_depth_ctrl.sv
module sleep_depth_ctrl
    import sdc_pkg::*;
#(
    parameter int IDLE_W  = 16,
    parameter int CNT_W   = 16,
    parameter int ENTER_L = 2,
    parameter int ENTER_H = 2,
    parameter int WAKE    = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [IDLE_W-1:0] idle_len_i,
    input  logic              irq_i,
    input  logic              ban_heavy_i,
    input  logic              tick_i,
    output logic [1:0]        mode_o,
    output logic              enter_o,
    output logic              exit_o,
    output logic              ready_o,
    output logic [CNT_W-1:0]  normal_time_o,
    output logic [CNT_W-1:0]  light_time_o,
    output logic [CNT_W-1:0]  heavy_time_o,
    output logic [CNT_W-1:0]  err_cnt_o
);
    localparam int NUM_MODES = 3;
    localparam int SEG_MAX   = (ENTER_L > ENTER_H) ? ENTER_L : ENTER_H;
    localparam int SEG_W     = $clog2(SEG_MAX + 1);
    localparam logic [IDLE_W-1:0] REM_WAKE = IDLE_W'(WAKE);
    localparam logic [IDLE_W-1:0] REM_LAST = IDLE_W'(WAKE + 1);
    localparam logic [SEG_W-1:0]  SEG_ONE  = SEG_W'(1);

    typedef struct packed {
        sdc_state_e        state;
        sdc_mode_e         mode;
        logic [IDLE_W-1:0] rem;   // ticks left until the next task is due
        logic [SEG_W-1:0]  seg;   // ticks left in the current entry step
        logic              deep;  // heavy sleep is the target
    } ctrl_t;

    ctrl_t     ctl_d, ctl_q;
    sdc_mode_e pick;

    sdc_depth_pick #(
        .IDLE_W (IDLE_W),
        .ENTER_L(ENTER_L),
        .ENTER_H(ENTER_H),
        .WAKE   (WAKE)
    ) u_pick (
        .idle_len_i (idle_len_i),
        .ban_heavy_i(ban_heavy_i),
        .depth_o    (pick)
    );

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.state)
            ST_AWAKE: begin
                if (start_i && pick != MODE_NORMAL) begin
                    ctl_d.state = ST_TO_LIGHT;
                    ctl_d.rem   = idle_len_i;
                    ctl_d.seg   = SEG_W'(ENTER_L);
                    ctl_d.deep  = (pick == MODE_HEAVY);
                end
            end
            ST_TO_LIGHT: begin
                if (irq_i) begin
                    ctl_d.state = ST_WAKING;
                    ctl_d.rem   = REM_WAKE;
                end else if (tick_i) begin
                    ctl_d.rem = ctl_q.rem - IDLE_W'(1);
                    ctl_d.seg = ctl_q.seg - SEG_ONE;
                    if (ctl_q.seg == SEG_ONE) begin
                        ctl_d.mode = MODE_LIGHT;
                        if (ctl_q.deep) begin
                            ctl_d.state = ST_TO_HEAVY;
                            ctl_d.seg   = SEG_W'(ENTER_H);
                        end else begin
                            ctl_d.state = ST_SLEEP;
                        end
                    end
                end
            end
            ST_TO_HEAVY: begin
                if (irq_i) begin
                    ctl_d.state = ST_WAKING;
                    ctl_d.rem   = REM_WAKE;
                end else if (tick_i) begin
                    ctl_d.rem = ctl_q.rem - IDLE_W'(1);
                    ctl_d.seg = ctl_q.seg - SEG_ONE;
                    if (ctl_q.seg == SEG_ONE) begin
                        ctl_d.mode  = MODE_HEAVY;
                        ctl_d.state = ST_SLEEP;
                    end
                end
            end
            ST_SLEEP: begin
                if (irq_i) begin
                    ctl_d.state = ST_WAKING;
                    ctl_d.rem   = REM_WAKE;
                end else if (tick_i) begin
                    ctl_d.rem = ctl_q.rem - IDLE_W'(1);
                    if (ctl_q.rem == REM_LAST) begin
                        ctl_d.state = ST_WAKING;
                    end
                end
            end
            ST_WAKING: begin
                if (tick_i) begin
                    ctl_d.rem = ctl_q.rem - IDLE_W'(1);
                    if (ctl_q.rem == IDLE_W'(1)) begin
                        ctl_d.state = ST_AWAKE;
                        ctl_d.mode  = MODE_NORMAL;
                    end
                end
            end
            default: begin
                ctl_d.state = ST_AWAKE;
                ctl_d.mode  = MODE_NORMAL;
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ctl_q <= '{state: ST_AWAKE, mode: MODE_NORMAL, rem: '0, seg: '0, deep: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign mode_o  = ctl_q.mode;
    assign ready_o = (ctl_q.state == ST_AWAKE);
    assign exit_o  = (ctl_q.state == ST_WAKING);
    assign enter_o = (ctl_q.state == ST_TO_LIGHT) || (ctl_q.state == ST_TO_HEAVY);

    logic [CNT_W-1:0] time_cnt [NUM_MODES];

    for (genvar g = 0; g < NUM_MODES; g++) begin : g_mode_time
        sdc_event_cnt #(.CNT_W(CNT_W)) u_time (
            .clk_i (clk_i),
            .rst_ni(rst_ni),
            .inc_i (tick_i && (ctl_q.mode == sdc_mode_e'(g))),
            .cnt_o (time_cnt[g])
        );
    end

    assign normal_time_o = time_cnt[0];
    assign light_time_o  = time_cnt[1];
    assign heavy_time_o  = time_cnt[2];

    sdc_event_cnt #(.CNT_W(CNT_W)) u_err (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .inc_i (start_i && !ready_o),
        .cnt_o (err_cnt_o)
    );
endmodule

// File: rtl/sdc_checker.sv
module sdc_checker #(
    parameter int IDLE_W  = 16,
    parameter int CNT_W   = 16,
    parameter int ENTER_L = 2,
    parameter int WAKE    = 2
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              start_i,
    input logic [IDLE_W-1:0] idle_len_i,
    input logic              irq_i,
    input logic [1:0]        mode_o,
    input logic              enter_o,
    input logic              exit_o,
    input logic              ready_o,
    input logic [CNT_W-1:0]  err_cnt_o
);
    localparam logic [IDLE_W-1:0] SHORT_LIM = IDLE_W'(ENTER_L + WAKE + 1);

    AST_MODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mode_o != 2'd3); // R11
    AST_CMD_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(enter_o && exit_o)); // R11
    AST_READY_AWAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ready_o |-> (mode_o == 2'd0 && !enter_o && !exit_o)); // R11
    AST_HEAVY_VIA_LIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_o == 2'd0) |=> (mode_o != 2'd2)); // R4
    AST_NO_HEAVY_TO_LIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_o == 2'd2) |=> (mode_o != 2'd1)); // R7
    AST_EXIT_ENDS_AWAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(exit_o) |-> (ready_o && mode_o == 2'd0)); // R7
    AST_SHORT_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && ready_o && idle_len_i < SHORT_LIM) |=> ready_o); // R2
    AST_IRQ_WAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_i && !ready_o && !exit_o) |=> exit_o); // R8
    AST_BUSY_START_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !ready_o) |=> (err_cnt_o == $past(err_cnt_o) + CNT_W'(1))); // R9
endmodule

bind sleep_depth_ctrl sdc_checker #(
    .IDLE_W (IDLE_W),
    .CNT_W  (CNT_W),
    .ENTER_L(ENTER_L),
    .WAKE   (WAKE)
) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .idle_len_i(idle_len_i),
    .irq_i     (irq_i),
    .mode_o    (mode_o),
    .enter_o   (enter_o),
    .exit_o    (exit_o),
    .ready_o   (ready_o),
    .err_cnt_o (err_cnt_o)
);

// File: tb/sleep_depth_ctrl_tb.sv
module sleep_depth_ctrl_tb;
    localparam int IDLE_W = 16;
    localparam int CNT_W  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [IDLE_W-1:0] idle_len = '0;
    logic              irq = 1'b0;
    logic              ban = 1'b0;
    logic              tick = 1'b0;
    logic [1:0]        mode;
    logic              enter, exit_c, ready;
    logic [CNT_W-1:0]  t_norm, t_light, t_heavy, err_cnt;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    sleep_depth_ctrl #(.IDLE_W(IDLE_W), .CNT_W(CNT_W)) u_dut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .start_i      (start),
        .idle_len_i   (idle_len),
        .irq_i        (irq),
        .ban_heavy_i  (ban),
        .tick_i       (tick),
        .mode_o       (mode),
        .enter_o      (enter),
        .exit_o       (exit_c),
        .ready_o      (ready),
        .normal_time_o(t_norm),
        .light_time_o (t_light),
        .heavy_time_o (t_heavy),
        .err_cnt_o    (err_cnt)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
    endtask

    task automatic strobe(input int len, input bit b);
        @(negedge clk);
        start = 1'b1; idle_len = IDLE_W'(len); ban = b;
        @(negedge clk);
        start = 1'b0; ban = 1'b0;
    endtask

    task automatic pulse_irq();
        @(negedge clk) irq = 1'b1;
        @(negedge clk) irq = 1'b0;
    endtask

    // full window with expected depth; checks sequencing, wake timing and counters
    task automatic run_window(input string req, input int len, input bit b, input bit deep);
        int n0, l0, h0;
        n0 = t_norm; l0 = t_light; h0 = t_heavy;
        strobe(len, b);
        check(req, "enter after strobe", enter, 1);
        ticks(2);
        check(req, "mode after light entry", mode, 1);
        check(req, "enter during heavy step", enter, deep);
        if (deep) begin
            ticks(2);
            check("R4", "mode after heavy entry", mode, 2);
            check("R4", "enter done", enter, 0);
        end
        ticks(len - 2 - (deep ? 4 : 2));
        check("R6", "exit with 2 ticks left", exit_c, 1);
        ticks(1);
        check("R6", "not ready one tick early", ready, 0);
        ticks(1);
        check("R6", "ready at window end", ready, 1);
        check("R7", "back in normal", mode, 0);
        check("R10", "normal ticks", t_norm - n0, 2);
        check("R10", "light ticks", t_light - l0, deep ? 2 : len - 2);
        check("R10", "heavy ticks", t_heavy - h0, deep ? len - 4 : 0);
    endtask

    task automatic t_reset();
        check("R1", "mode", mode, 0);
        check("R1", "ready", ready, 1);
        check("R1", "enter|exit", {enter, exit_c}, 0);
        check("R1", "counters", t_norm + t_light + t_heavy + err_cnt, 0);
    endtask

    task automatic t_short();
        for (int len = 3; len <= 4; len++) begin
            strobe(len, 1'b0);
            check("R2", "ready after short strobe", ready, 1);
            check("R2", "no entry", enter, 0);
            ticks(len);
            check("R2", "mode stays normal", mode, 0);
        end
    endtask

    task automatic t_irq_entry();
        strobe(10, 1'b0);
        ticks(1);
        pulse_irq();
        check("R8", "exit after irq in entry", exit_c, 1);
        check("R8", "mode still normal", mode, 0);
        ticks(1);
        check("R8", "still waking", ready, 0);
        ticks(1);
        check("R8", "ready after wake", ready, 1);
    endtask

    task automatic t_irq_heavy();
        strobe(20, 1'b0);
        ticks(5);
        check("R4", "heavy reached", mode, 2);
        pulse_irq();
        check("R8", "exit after irq in heavy", exit_c, 1);
        ticks(1);
        check("R8", "waking", ready, 0);
        ticks(1);
        check("R8", "ready after wake", ready, 1);
        check("R7", "wake lands normal", mode, 0);
    endtask

    task automatic t_irq_awake();
        pulse_irq();
        check("R8", "irq in normal no exit", exit_c, 0);
        check("R8", "irq in normal ready", ready, 1);
    endtask

    task automatic t_busy_start();
        int e0;
        e0 = err_cnt;
        strobe(10, 1'b0);
        ticks(1);
        strobe(3, 1'b0);
        check("R9", "error counted", err_cnt - e0, 1);
        check("R9", "entry not disturbed", enter, 1);
        ticks(8);
        check("R9", "original window kept", ready, 0);
        ticks(1);
        check("R9", "ready at original end", ready, 1);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_short();
        run_window("R3", 5, 1'b0, 1'b0);
        run_window("R3", 6, 1'b0, 1'b0);
        run_window("R4", 7, 1'b0, 1'b1);
        run_window("R4", 12, 1'b0, 1'b1);
        run_window("R5", 9, 1'b1, 1'b0);
        t_irq_entry();
        t_irq_heavy();
        t_irq_awake();
        t_busy_start();
        finished = 1'b1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end
endmodule